// File: doc/BRIEF.md
# SPI Controller with Partial-Reset Enable

This block is a byte-wide SPI controller that a CPU drives through a small register interface: a control register, a status/configuration register and a data address. Writing the data address loads the transmit buffer, and reading it returns the receive buffer. As master it generates SCK from the bus clock and shifts bytes MSB first. As slave it follows an external SCK while SS is low. It raises a receive interrupt when a byte arrives and an error interrupt for overflow or mode fault.

The main point of the design is how it resets. A system reset clears everything. Dropping the enable bit aborts only the transfer path: the shifter, the bit counter and the engine state are flushed, the transmit buffer is reported empty, and the pins go back to general-purpose I/O. Configuration bits and pending flags are kept. A master that sees SS pulled low while mode-fault detection is on clears its own enable bit. A stop input freezes every register until it is released.

The shift engine has three states. ST_IDLE waits. ST_IDLE→ST_LOW (start) happens when a master holds a pending byte, or when a slave sees SS low. ST_LOW→ST_HIGH (sample) happens on a divider tick or an incoming SCK rise. ST_HIGH→ST_LOW (shift) happens on the next tick or SCK fall while bits remain. ST_HIGH→ST_IDLE (finish) happens after the last bit. ST_LOW/ST_HIGH→ST_IDLE (abort) happens when enable is 0, or when a slave sees SS rise.

Top module: `spi_ctl`

## Requirements
- R1: After system reset the control register reads 0x00, the status register reads 0x80 (only transmit-empty set), and pins_owned, sck_out, irq_rx and irq_err are all 0.
- R2: While enable (control bit 0) is 0, transmit-empty (status bit 7) is held at 1, even when the data address is written. Any transfer stops, sck_out and mosi_out go low, and the next transfer after re-enabling starts from its first bit.
- R3: pins_owned equals the enable bit, so the block releases its pins whenever it is disabled.
- R4: Clearing enable leaves master (control bit 1), receive-interrupt enable (control bit 2), rate select (status bits 1:0), mode-fault enable (status bit 2) and error-interrupt enable (status bit 3) unchanged.
- R5: Receive-full (status bit 4), overflow (status bit 5) and mode-fault (status bit 6) survive clearing of enable, and so do their interrupt requests.
- R6: Register map: address 0 is control, 1 is status, 2 is data. In master mode a written byte goes out MSB first on mosi_out, and the byte sampled on miso_in is read back from address 2. Reading address 2 clears receive-full. Writing 1 to status bit 5 or bit 6 clears that flag.
- R7: Rate select 0, 1, 2 and 3 gives an SCK period of 2, 8, 32 and 128 bus clocks.
- R8: When a byte completes while receive-full is still 1, overflow is set and the receive buffer keeps the older byte.
- R9: irq_rx = receive-full AND receive-interrupt enable. irq_err is 1 only when error-interrupt enable is 1 and overflow or mode-fault is set.
- R10: A master with mode-fault enable set that sees ss_n low sets mode-fault and clears enable, keeping its other control bits. With mode-fault enable clear, nothing happens.
- R11: While stop is 1, no register or output changes and register writes are ignored. After stop is released, the transfer completes with the correct byte.
- R12: A system reset during stop discards the pending transfer and restores the R1 state.
- R13: In slave mode with ss_n low, the block samples mosi_in on each rising sck_in, drives its transmit byte MSB first on miso_out, and stores the received byte after the eighth falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| stop | input | 1 | Stop request; freezes the whole block |
| addr | input | 2 | Register address |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effect on data reads) |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for addr |
| sck_in | input | 1 | Serial clock from a remote master |
| sck_out | output | 1 | Serial clock driven as master |
| mosi_in | input | 1 | Serial data in, slave mode |
| mosi_out | output | 1 | Serial data out, master mode |
| miso_in | input | 1 | Serial data in, master mode |
| miso_out | output | 1 | Serial data out, slave mode |
| ss_n | input | 1 | Slave select, active low |
| pins_owned | output | 1 | 1 while the block owns its pins |
| irq_rx | output | 1 | Receive interrupt request |
| irq_err | output | 1 | Error interrupt request |

## Verification
The bench disables the block in the middle of a slow transfer. A design that reset configuration or flags on disable would lose the rate, the mode-fault enable or the pending receive byte. A design that kept its bit counter would shift a garbled byte after re-enabling. It provokes overflow to catch a buffer that gets overwritten, and drives ss_n low with and without mode-fault enable to catch a fault that fails to clear enable, or that fires when it should not. It holds stop in the middle of a transfer and then resets during stop, which exposes logic that keeps running, accepts writes while frozen, or resumes a stale transfer.

// File: rtl/spi_pkg.sv
package spi_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH
    } eng_state_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

    // status register bit positions
    localparam int SB_MODFEN = 2;
    localparam int SB_ERRIE  = 3;
    localparam int SB_OVR    = 5;
    localparam int SB_MODF   = 6;

endpackage

// File: rtl/spi_clkdiv.sv
module spi_clkdiv #(
    parameter int CNT_W = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hold,
    input  logic       run,
    input  logic [1:0] rate,
    output logic       tick
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    // half period = 4^rate bus clocks
    assign limit = CNT_W'(1) << {rate, 1'b0};
    assign tick  = run && (cnt_q == limit - CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!hold) begin
            if (!run || tick) cnt_q <= '0;
            else              cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/spi_engine.sv
module spi_engine
    import spi_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              en,
    input  logic              master,
    input  logic              tick,
    input  logic              sck_in,
    input  logic              mosi_in,
    input  logic              miso_in,
    input  logic              ss_n,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_byte,
    output logic              tx_take,
    output logic              done,
    output logic              busy,
    output logic              sck_out,
    output logic              ser_out,
    output logic [DATA_W-1:0] rx_byte
);
    localparam int CW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

    eng_state_e state_q, state_d;
    logic [DATA_W-1:0] shreg_q;
    logic [CW-1:0]     bit_q;
    logic              samp_q, sck_prev_q;
    logic              slave_live, edge_in, edge_out, start;

    assign slave_live = ~master & ~ss_n;
    assign edge_in    = master ? tick : (sck_in & ~sck_prev_q & slave_live);
    assign edge_out   = master ? tick : (~sck_in & sck_prev_q & slave_live);
    assign start      = master ? tx_valid : ~ss_n;

    always_comb begin
        state_d = state_q;
        if (!hold) begin
            if (!en) begin
                state_d = ST_IDLE;
            end else begin
                unique case (state_q)
                    ST_IDLE: if (start) state_d = ST_LOW;
                    ST_LOW: begin
                        if (!master && ss_n) state_d = ST_IDLE;
                        else if (edge_in)    state_d = ST_HIGH;
                    end
                    ST_HIGH: begin
                        if (!master && ss_n) state_d = ST_IDLE;
                        else if (edge_out)   state_d = (bit_q == LAST) ? ST_IDLE : ST_LOW;
                    end
                    default: state_d = ST_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q    <= '0;
            bit_q      <= '0;
            samp_q     <= 1'b0;
            sck_prev_q <= 1'b0;
        end else if (!hold) begin
            sck_prev_q <= sck_in;
            if (!en) begin
                shreg_q <= '0;
                bit_q   <= '0;
                samp_q  <= 1'b0;
            end else if (state_q == ST_IDLE && state_d == ST_LOW) begin
                shreg_q <= tx_valid ? tx_byte : '0;
                bit_q   <= '0;
            end else if (state_q == ST_LOW && state_d == ST_HIGH) begin
                samp_q <= master ? miso_in : mosi_in;
            end else if (state_q == ST_HIGH && edge_out) begin
                shreg_q <= {shreg_q[DATA_W-2:0], samp_q};
                bit_q   <= bit_q + CW'(1);
            end
        end
    end

    always_comb begin
        tx_take = !hold && en && state_q == ST_IDLE && state_d == ST_LOW && tx_valid;
        done    = !hold && en && state_q == ST_HIGH && edge_out && bit_q == LAST;
        busy    = state_q != ST_IDLE;
        sck_out = master && state_q == ST_HIGH;
        ser_out = shreg_q[DATA_W-1];
        rx_byte = {shreg_q[DATA_W-2:0], samp_q};
    end
endmodule

// File: rtl/spi_ctl.sv
module spi_ctl
    import spi_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stop,
    input  logic [1:0]        addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              sck_in,
    output logic              sck_out,
    input  logic              mosi_in,
    output logic              mosi_out,
    input  logic              miso_in,
    output logic              miso_out,
    input  logic              ss_n,
    output logic              pins_owned,
    output logic              irq_rx,
    output logic              irq_err
);
    logic              en_q, master_q, rxie_q;
    logic [1:0]        rate_q;
    logic              modfen_q, errie_q;
    logic              rx_full_q, ovr_q, modf_q, tx_empty_q;
    logic [DATA_W-1:0] txbuf_q, rxbuf_q, rx_byte;
    logic              tick, tx_take, done, busy, eng_sck, ser_out;
    logic              modf_hit, wr_ctrl, wr_stat, wr_data, rd_data;

    assign wr_ctrl  = wr_en && addr == ADDR_CTRL;
    assign wr_stat  = wr_en && addr == ADDR_STAT;
    assign wr_data  = wr_en && addr == ADDR_DATA;
    assign rd_data  = rd_en && addr == ADDR_DATA;
    assign modf_hit = en_q && master_q && modfen_q && !ss_n;

    spi_clkdiv #(.CNT_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .hold(stop),
        .run(busy && master_q && en_q), .rate(rate_q), .tick(tick)
    );

    spi_engine #(.DATA_W(DATA_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .hold(stop), .en(en_q), .master(master_q),
        .tick(tick), .sck_in(sck_in), .mosi_in(mosi_in), .miso_in(miso_in),
        .ss_n(ss_n), .tx_valid(!tx_empty_q), .tx_byte(txbuf_q),
        .tx_take(tx_take), .done(done), .busy(busy), .sck_out(eng_sck),
        .ser_out(ser_out), .rx_byte(rx_byte)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q       <= 1'b0;
            master_q   <= 1'b0;
            rxie_q     <= 1'b0;
            rate_q     <= 2'd0;
            modfen_q   <= 1'b0;
            errie_q    <= 1'b0;
            rx_full_q  <= 1'b0;
            ovr_q      <= 1'b0;
            modf_q     <= 1'b0;
            tx_empty_q <= 1'b1;
            txbuf_q    <= '0;
            rxbuf_q    <= '0;
        end else if (!stop) begin
            if (wr_ctrl) begin
                en_q     <= wdata[0];
                master_q <= wdata[1];
                rxie_q   <= wdata[2];
            end
            if (wr_stat) begin
                rate_q   <= wdata[1:0];
                modfen_q <= wdata[SB_MODFEN];
                errie_q  <= wdata[SB_ERRIE];
                if (wdata[SB_OVR])  ovr_q  <= 1'b0;
                if (wdata[SB_MODF]) modf_q <= 1'b0;
            end
            if (modf_hit) begin
                modf_q <= 1'b1;
                en_q   <= 1'b0;
            end
            if (wr_data) txbuf_q <= wdata;
            if (!en_q)        tx_empty_q <= 1'b1;
            else if (wr_data) tx_empty_q <= 1'b0;
            else if (tx_take) tx_empty_q <= 1'b1;
            if (done) begin
                if (rx_full_q) begin
                    ovr_q <= 1'b1;
                end else begin
                    rxbuf_q   <= rx_byte;
                    rx_full_q <= 1'b1;
                end
            end else if (rd_data) begin
                rx_full_q <= 1'b0;
            end
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            ADDR_CTRL: rdata[7:0] = {5'b0, rxie_q, master_q, en_q};
            ADDR_STAT: rdata[7:0] = {tx_empty_q, modf_q, ovr_q, rx_full_q,
                                     errie_q, modfen_q, rate_q};
            ADDR_DATA: rdata = rxbuf_q;
            default:   rdata = '0;
        endcase
        sck_out    = en_q && eng_sck;
        mosi_out   = en_q && master_q && ser_out;
        miso_out   = en_q && !master_q && !ss_n && ser_out;
        pins_owned = en_q;
        irq_rx     = rx_full_q && rxie_q;
        irq_err    = errie_q && (ovr_q || modf_q);
    end
endmodule

// File: rtl/spi_ctl_chk.sv
module spi_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       stop,
    input logic       en,
    input logic       wr_en,
    input logic       rd_en,
    input logic [1:0] addr,
    input logic       tx_empty,
    input logic       sck_out,
    input logic       mosi_out,
    input logic [1:0] rate,
    input logic       modfen,
    input logic       errie,
    input logic       master,
    input logic       rxie,
    input logic       rx_full,
    input logic       ovr,
    input logic       modf,
    input logic       irq_err
);
    assert_txe_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !stop) |=> (tx_empty && !sck_out));

    assert_cfg_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop && !(wr_en && addr == 2'd1)) |=> $stable({rate, modfen, errie}));

    assert_ctrl_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop && !(wr_en && addr == 2'd0)) |=> $stable({master, rxie}));

    assert_flags_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !stop && !wr_en && !rd_en) |=> $stable({rx_full, ovr, modf}));

    assert_ovr_needs_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> rx_full);

    assert_irq_err_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err |-> errie);

    assert_modf_disables_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(modf) |-> !en);

    assert_stop_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> ($stable(sck_out) && $stable(mosi_out) && $stable(tx_empty) && $stable(en)));
endmodule

bind spi_ctl spi_ctl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .stop(stop), .en(en_q), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .tx_empty(tx_empty_q), .sck_out(sck_out),
    .mosi_out(mosi_out), .rate(rate_q), .modfen(modfen_q), .errie(errie_q),
    .master(master_q), .rxie(rxie_q), .rx_full(rx_full_q), .ovr(ovr_q),
    .modf(modf_q), .irq_err(irq_err)
);

// File: tb/sim_spi_ctl.sv
module sim_spi_ctl;
    localparam int CLK_P = 10;
    localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2;
    // vector: {rate, tx byte, invert miso}
    localparam logic [10:0] VEC [0:5] = '{
        {2'd0, 8'hA5, 1'b0}, {2'd0, 8'h3C, 1'b1}, {2'd1, 8'h81, 1'b0},
        {2'd2, 8'h7E, 1'b1}, {2'd3, 8'hC9, 1'b0}, {2'd1, 8'h00, 1'b1}
    };

    logic clk = 0, rst_n = 0, stop = 0, wr_en = 0, rd_en = 0;
    logic [1:0] addr = 0;
    logic [7:0] wdata = 0, rdata;
    logic sck_in = 0, mosi_in = 0, ss_n = 1, inv_q = 0;
    logic sck_out, mosi_out, miso_in, miso_out, pins_owned, irq_rx, irq_err;
    int errors = 0, checks = 0, cyc = 0, last_rise = 0, period = 0;
    logic [7:0] v, got;

    assign miso_in = mosi_out ^ inv_q;

    spi_ctl u0 (
        .clk(clk), .rst_n(rst_n), .stop(stop), .addr(addr), .wr_en(wr_en),
        .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .sck_in(sck_in),
        .sck_out(sck_out), .mosi_in(mosi_in), .mosi_out(mosi_out),
        .miso_in(miso_in), .miso_out(miso_out), .ss_n(ss_n),
        .pins_owned(pins_owned), .irq_rx(irq_rx), .irq_err(irq_err)
    );

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) cyc++;
    always @(posedge sck_out) begin
        period = cyc - last_rise;
        last_rise = cyc;
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        addr = a; #1 d = rdata;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd_en = 1; #1 d = rdata;
        @(negedge clk); rd_en = 0;
    endtask

    task automatic wait_full();
        logic [7:0] s;
        for (int k = 0; k < 5000; k++) begin
            @(negedge clk); peek(A_STAT, s);
            if (s[4]) break;
        end
    endtask

    task automatic xfer(input logic [7:0] tx, input logic inv, output logic [7:0] rx);
        inv_q = inv;
        wr(A_DATA, tx);
        wait_full();
        rd(A_DATA, rx);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        peek(A_CTRL, v); chk("R1 ctrl", v, 8'h00);
        peek(A_STAT, v); chk("R1 stat", v, 8'h80);
        chk("R1 pins/sck/irq", {pins_owned, sck_out, irq_rx, irq_err}, 4'b0000);
        rst_n = 1;
        @(negedge clk);

        // R6 R7 R9 vector table, master loopback
        wr(A_CTRL, 8'h07);
        chk("R3 pins_owned on", pins_owned, 1'b1);
        for (int i = 0; i < 6; i++) begin
            wr(A_STAT, {6'b0, VEC[i][10:9]});
            inv_q = VEC[i][0];
            wr(A_DATA, VEC[i][8:1]);
            wait_full();
            chk("R9 irq_rx", irq_rx, 1'b1);
            rd(A_DATA, v);
            chk("R6 rx byte", v, VEC[i][8:1] ^ {8{VEC[i][0]}});
            chk("R7 sck period", period, 2 << (2 * VEC[i][10:9]));
        end
        inv_q = 0;

        // R8 overflow, R9 gating
        wr(A_CTRL, 8'h03); wr(A_STAT, 8'h00);
        inv_q = 0; wr(A_DATA, 8'h11); wait_full();
        wr(A_DATA, 8'h22); repeat (60) @(negedge clk);
        peek(A_STAT, v); chk("R8 ovr set", v[5], 1'b1);
        chk("R9 irq off without enables", {irq_rx, irq_err}, 2'b00);
        wr(A_STAT, 8'h08);
        chk("R9 irq_err with errie", irq_err, 1'b1);
        rd(A_DATA, v); chk("R8 older byte kept", v, 8'h11);
        wr(A_STAT, 8'h28);
        peek(A_STAT, v); chk("R6 ovr w1c", v, 8'h88);
        chk("R9 irq_err cleared", irq_err, 1'b0);

        // R2 R4 R5 partial reset
        wr(A_CTRL, 8'h07); wr(A_DATA, 8'h5A); wait_full();
        wr(A_STAT, 8'h0F); wr(A_DATA, 8'hC3);
        repeat (3) @(posedge sck_out);
        wr(A_CTRL, 8'h06);
        repeat (2) @(negedge clk);
        peek(A_CTRL, v); chk("R4 ctrl kept", v, 8'h06);
        peek(A_STAT, v); chk("R4 R5 stat kept", v, 8'h9F);
        chk("R3 pins released", pins_owned, 1'b0);
        chk("R2 pins quiet", {sck_out, mosi_out}, 2'b00);
        chk("R5 irq_rx kept", irq_rx, 1'b1);
        repeat (300) @(negedge clk);
        rd(A_DATA, v); chk("R5 rx byte kept", v, 8'h5A);
        wr(A_DATA, 8'h99);
        peek(A_STAT, v); chk("R2 tx empty forced", v[7], 1'b1);
        wr(A_STAT, 8'h0C); wr(A_CTRL, 8'h07);
        xfer(8'h3C, 1'b0, v); chk("R2 restart first bit", v, 8'h3C);

        // R10 mode fault
        @(negedge clk); ss_n = 0; repeat (3) @(negedge clk); ss_n = 1;
        peek(A_CTRL, v); chk("R10 enable cleared", v, 8'h06);
        peek(A_STAT, v); chk("R10 modf set", v, 8'hCC);
        chk("R10 irq_err/pins", {irq_err, pins_owned}, 2'b10);
        wr(A_STAT, 8'h48);
        wr(A_CTRL, 8'h07);
        @(negedge clk); ss_n = 0; repeat (3) @(negedge clk); ss_n = 1;
        peek(A_CTRL, v); chk("R10 no fault when disabled", v, 8'h07);
        peek(A_STAT, v); chk("R10 modf stays clear", v, 8'h88);

        // R11 stop
        wr(A_STAT, 8'h02); wr(A_DATA, 8'h6E);
        repeat (2) @(posedge sck_out);
        @(negedge clk); stop = 1; got = {6'b0, sck_out, mosi_out};
        repeat (50) @(negedge clk);
        wr(A_CTRL, 8'h00);
        repeat (50) @(negedge clk);
        chk("R11 outputs frozen", {6'b0, sck_out, mosi_out}, got);
        peek(A_CTRL, v); chk("R11 write ignored", v, 8'h07);
        stop = 0;
        wait_full(); rd(A_DATA, v); chk("R11 resumed byte", v, 8'h6E);

        // R13 slave
        wr(A_CTRL, 8'h05); wr(A_DATA, 8'hB4);
        @(negedge clk); ss_n = 0; repeat (4) @(negedge clk);
        for (int b = 7; b >= 0; b--) begin
            mosi_in = b[0] ? 1'b0 : 1'b1; // pattern 0x55 inverted on odd... gives 0x55
            repeat (3) @(negedge clk); got[b] = miso_out;
            sck_in = 1; repeat (3) @(negedge clk);
            sck_in = 0; repeat (3) @(negedge clk);
        end
        chk("R13 miso stream", got, 8'hB4);
        peek(A_STAT, v); chk("R13 rx full", v[4], 1'b1);
        rd(A_DATA, v); chk("R13 slave rx byte", v, 8'h55);
        ss_n = 1; mosi_in = 0;

        // R12 reset during stop
        wr(A_CTRL, 8'h07); wr(A_STAT, 8'h03); wr(A_DATA, 8'h81);
        @(posedge sck_out);
        @(negedge clk); stop = 1; repeat (5) @(negedge clk);
        rst_n = 0; repeat (3) @(negedge clk); rst_n = 1; stop = 0;
        repeat (2) @(negedge clk);
        peek(A_CTRL, v); chk("R12 ctrl cleared", v, 8'h00);
        peek(A_STAT, v); chk("R12 stat default", v, 8'h80);
        chk("R12 pins/sck", {pins_owned, sck_out}, 2'b00);
        repeat (300) @(negedge clk);
        peek(A_STAT, v); chk("R12 no stale byte", v, 8'h80);

        finish_run();
    end
endmodule